// File: doc/BRIEF.md
# DRAM Thermal Poll and Derate Controller

This block watches the die temperature of low-power DRAM. On a programmable number of refresh periods it asks the memory command path to read the temperature-status mode register of chip select 0 and, when enabled, of chip select 1. It folds the readings into one held temperature level. From that level it drives two selects. One switches the refresh rate to its derated set. The other also switches the core timing parameters to their derated set.

When the held level moves and alerts are enabled, a sticky status bit is set and the interrupt line rises. Software clears the bit by writing a one to it. The physical command issue is outside the block. It is reached through a request/acknowledge port that returns the mode-register byte.

A four-state machine sequences each poll:
- IDLE: the interval counter runs. IDLE goes to READ0 when the counter is due.
- READ0: the chip select 0 read is outstanding. On acknowledge it goes to READ1 if the second chip select was enabled at poll start, otherwise to APPLY.
- READ1: the chip select 1 read is outstanding. On acknowledge it goes to APPLY.
- APPLY: the new level and the status bit are written. APPLY always returns to IDLE after one cycle.

Top module: `dram_thermal_monitor`

## Requirements
- R1: After reset the held level is 3, both derate selects are 0, the alert status and interrupt are 0, and no read is requested.
- R2: In IDLE the block counts refresh ticks. The poll request (`mr_req`=1, `mr_cs`=0) appears in the cycle after the tick that completes `cfg_interval` ticks. An interval of 0 behaves as 1.
- R3: Chip select 0 is always read first. A request stays asserted with a stable `mr_cs` until acknowledged. Chip select 1 (`mr_cs`=1) is read after the chip select 0 acknowledge only if `cfg_cs1_en` was 1 when the poll started. Otherwise no second request is made.
- R4: The temperature code is bits [2:0] of `mr_data`; upper bits are ignored. With both chip selects read, the combined code is the larger of the two.
- R5: A combined code below 3 is taken as 3.
- R6: A combined code equal to 4 is discarded, and the held level keeps its previous value.
- R7: At level 5 only `sel_ref_derate` is 1. At levels 6 and 7 both `sel_ref_derate` and `sel_tim_derate` are 1. At level 3 both are 0.
- R8: The alert status is set when a completed poll changes the held level while `cfg_irq_en` is 1. It is not set when the level is unchanged or when the enable is 0.
- R9: Writing with `alert_clr_wr`=1 and `alert_clr_data`=1 clears the status; a write with data 0 has no effect. A set in the same cycle wins over the clear. `irq` always equals the status.
- R10: Refresh ticks that arrive while a poll is outstanding are ignored. After the final acknowledge the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| refresh_tick | input | 1 | One-cycle pulse per refresh period |
| cfg_interval | input | INTERVAL_W | Poll interval in refresh periods |
| cfg_cs1_en | input | 1 | Also read chip select 1 |
| cfg_irq_en | input | 1 | Allow level changes to set the status |
| mr_req | output | 1 | Mode-register read request |
| mr_cs | output | 1 | Chip select of the request |
| mr_ack | input | 1 | Request accepted, data valid |
| mr_data | input | MR_DATA_W | Returned mode-register byte |
| alert_clr_wr | input | 1 | Status write strobe |
| alert_clr_data | input | 1 | Written bit, one clears |
| alert_status | output | 1 | Sticky level-change status |
| irq | output | 1 | Interrupt line |
| temp_level | output | 3 | Held temperature level |
| sel_ref_derate | output | 1 | Use derated refresh settings |
| sel_tim_derate | output | 1 | Use derated core timing sets |

## Verification
The bench builds the block with INTERVAL_W of 4 and the default 8-bit data width. A 4-bit interval makes the largest count of 15 ticks reachable in a few hundred cycles, so both ends of the interval range are exercised. The 8-bit data lets the bench put junk in the upper bits of a reading and confirm that it is ignored. Under these values every level transition can be driven directly: clamping, the discarded reserved code, derate decoding, ticks that arrive during a slow acknowledge, and a clear that collides with a set.

// File: rtl/thm_pkg.sv
package thm_pkg;
    localparam int CODE_W = 3;
    typedef logic [CODE_W-1:0] tcode_t;

    localparam tcode_t CODE_NOMINAL    = 3'd3;
    localparam tcode_t CODE_RESERVED   = 3'd4;
    localparam tcode_t CODE_DERATE_REF = 3'd5;
    localparam tcode_t CODE_DERATE_ALL = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ0 = 2'd1,
        ST_READ1 = 2'd2,
        ST_APPLY = 2'd3
    } poll_state_t;
endpackage

// File: rtl/thm_interval_timer.sv
module thm_interval_timer #(
    parameter int INTERVAL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  refresh_tick,
    input  logic                  idle,
    input  logic [INTERVAL_W-1:0] interval,
    output logic                  poll_due
);
    localparam int CW = INTERVAL_W + 1;

    logic [INTERVAL_W-1:0] cnt_q;
    logic [CW-1:0]         limit;
    logic [CW-1:0]         next_cnt;
    logic                  reach;

    assign limit    = (interval == '0) ? CW'(1) : {1'b0, interval};
    assign next_cnt = {1'b0, cnt_q} + CW'(1);
    assign reach    = next_cnt >= limit;
    assign poll_due = idle && refresh_tick && reach;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!idle) begin
            cnt_q <= '0;
        end else if (refresh_tick) begin
            cnt_q <= reach ? '0 : next_cnt[INTERVAL_W-1:0];
        end
    end

    // R10: no tick is accumulated while a poll is in flight
    assert_busy_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && refresh_tick) |=> (cnt_q == '0));
endmodule

// File: rtl/thm_level_filter.sv
module thm_level_filter
    import thm_pkg::*;
(
    input  tcode_t rd0,
    input  tcode_t rd1,
    input  logic   use1,
    input  tcode_t held,
    output tcode_t next_level,
    output logic   changed
);
    tcode_t merged;
    tcode_t clamped;

    always_comb begin
        merged     = (use1 && (rd1 > rd0)) ? rd1 : rd0;
        clamped    = (merged < CODE_NOMINAL) ? CODE_NOMINAL : merged;
        next_level = (clamped == CODE_RESERVED) ? held : clamped;
        changed    = (next_level != held);
    end
endmodule

// File: rtl/thm_poll_fsm.sv
module thm_poll_fsm
    import thm_pkg::*;
#(
    parameter int MR_DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 poll_due,
    input  logic                 cs1_cfg,
    input  logic                 mr_ack,
    input  logic [MR_DATA_W-1:0] mr_data,
    output logic                 mr_req,
    output logic                 mr_cs,
    output logic                 idle,
    output logic                 apply,
    output tcode_t               rd0,
    output tcode_t               rd1,
    output logic                 use1
);
    poll_state_t state_q, state_d;
    logic        unused_hi_bits;

    assign unused_hi_bits = ^mr_data[MR_DATA_W-1:CODE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (poll_due) state_d = ST_READ0;
            ST_READ0: if (mr_ack)   state_d = use1 ? ST_READ1 : ST_APPLY;
            ST_READ1: if (mr_ack)   state_d = ST_APPLY;
            ST_APPLY:               state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        idle   = 1'b0;
        apply  = 1'b0;
        mr_req = 1'b0;
        mr_cs  = 1'b0;
        unique case (state_q)
            ST_IDLE:  idle = 1'b1;
            ST_READ0: mr_req = 1'b1;
            ST_READ1: begin mr_req = 1'b1; mr_cs = 1'b1; end
            ST_APPLY: apply = 1'b1;
            default:  idle = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd0  <= CODE_NOMINAL;
            rd1  <= CODE_NOMINAL;
            use1 <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && poll_due)  use1 <= cs1_cfg;
            if (state_q == ST_READ0 && mr_ack)   rd0  <= mr_data[CODE_W-1:0];
            if (state_q == ST_READ1 && mr_ack)   rd1  <= mr_data[CODE_W-1:0];
        end
    end

    // R3: an unanswered request is held with the same chip select
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mr_req && !mr_ack) |=> (mr_req && $stable(mr_cs)));

    // R3: a chip select 1 read only follows a chip select 0 acknowledge
    assert_cs1_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mr_cs) |-> $past(mr_req && mr_ack && !mr_cs));
endmodule

// File: rtl/dram_thermal_monitor.sv
module dram_thermal_monitor
    import thm_pkg::*;
#(
    parameter int INTERVAL_W = 8,
    parameter int MR_DATA_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  refresh_tick,
    input  logic [INTERVAL_W-1:0] cfg_interval,
    input  logic                  cfg_cs1_en,
    input  logic                  cfg_irq_en,
    output logic                  mr_req,
    output logic                  mr_cs,
    input  logic                  mr_ack,
    input  logic [MR_DATA_W-1:0]  mr_data,
    input  logic                  alert_clr_wr,
    input  logic                  alert_clr_data,
    output logic                  alert_status,
    output logic                  irq,
    output logic [2:0]            temp_level,
    output logic                  sel_ref_derate,
    output logic                  sel_tim_derate
);
    logic   idle, apply, poll_due, use1, changed;
    tcode_t rd0, rd1, next_level, level_q;

    thm_interval_timer #(.INTERVAL_W(INTERVAL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
        .idle(idle), .interval(cfg_interval), .poll_due(poll_due)
    );

    thm_poll_fsm #(.MR_DATA_W(MR_DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .poll_due(poll_due), .cs1_cfg(cfg_cs1_en),
        .mr_ack(mr_ack), .mr_data(mr_data), .mr_req(mr_req), .mr_cs(mr_cs),
        .idle(idle), .apply(apply), .rd0(rd0), .rd1(rd1), .use1(use1)
    );

    thm_level_filter u_filter (
        .rd0(rd0), .rd1(rd1), .use1(use1), .held(level_q),
        .next_level(next_level), .changed(changed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q      <= CODE_NOMINAL;
            alert_status <= 1'b0;
        end else begin
            if (apply) level_q <= next_level;
            alert_status <= (alert_status && !(alert_clr_wr && alert_clr_data))
                          || (apply && changed && cfg_irq_en);
        end
    end

    assign temp_level     = level_q;
    assign irq            = alert_status;
    assign sel_ref_derate = (level_q >= CODE_DERATE_REF);
    assign sel_tim_derate = (level_q >= CODE_DERATE_ALL);

    // R5 and R6: the held level never drops below nominal nor takes the reserved code
    assert_level_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_level >= 3'd3) && (temp_level != 3'd4));

    // R7: the timing derate never appears without the refresh derate
    assert_sel_nest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_tim_derate |-> sel_ref_derate);

    // R8: status only rises on an enabled level change
    assert_alert_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alert_status) |-> ($past(cfg_irq_en) && (temp_level != $past(temp_level))));

    // R9: status only falls after a clearing write
    assert_alert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_status) |-> $past(alert_clr_wr && alert_clr_data));
endmodule

// File: tb/test_dram_thermal_monitor.sv
module test_dram_thermal_monitor;
    localparam int IW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_tick = 1'b0;
    logic [IW-1:0] cfg_interval = '0;
    logic          cfg_cs1_en = 1'b0;
    logic          cfg_irq_en = 1'b1;
    logic          mr_req, mr_cs;
    logic          mr_ack = 1'b0;
    logic [DW-1:0] mr_data = '0;
    logic          alert_clr_wr = 1'b0;
    logic          alert_clr_data = 1'b0;
    logic          alert_status, irq;
    logic [2:0]    temp_level;
    logic          sel_ref_derate, sel_tim_derate;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [2:0] lvl;
        logic       st;
        string      tag;
    } exp_t;
    exp_t exp_q[$];
    event done_ev;

    logic [2:0] m_level = 3'd3;
    logic       m_status = 1'b0;

    always #2 clk = ~clk;

    dram_thermal_monitor #(.INTERVAL_W(IW), .MR_DATA_W(DW)) i_dram_thermal_monitor (
        .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
        .cfg_interval(cfg_interval), .cfg_cs1_en(cfg_cs1_en), .cfg_irq_en(cfg_irq_en),
        .mr_req(mr_req), .mr_cs(mr_cs), .mr_ack(mr_ack), .mr_data(mr_data),
        .alert_clr_wr(alert_clr_wr), .alert_clr_data(alert_clr_data),
        .alert_status(alert_status), .irq(irq), .temp_level(temp_level),
        .sel_ref_derate(sel_ref_derate), .sel_tim_derate(sel_tim_derate)
    );

    task automatic chk(input string rq, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, expv);
        end
    endtask

    task automatic tick_pulse();
        @(negedge clk) refresh_tick = 1'b1;
        @(negedge clk) refresh_tick = 1'b0;
    endtask

    // monitor: pops the expected outcome of each poll and compares at the ports
    initial begin
        forever begin
            @(done_ev);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "temp_level", int'(temp_level), int'(e.lvl));
                chk("R7", "sel_ref_derate", int'(sel_ref_derate), int'(e.lvl >= 3'd5));
                chk("R7", "sel_tim_derate", int'(sel_tim_derate), int'(e.lvl >= 3'd6));
                chk("R8", "alert_status", int'(alert_status), int'(e.st));
                chk("R9", "irq", int'(irq), int'(e.st));
            end
        end
    end

    // driver: runs one poll and pushes the model's expected result
    task automatic poll(input logic [7:0] d0, input logic [7:0] d1, input bit en1,
                        input int nticks, input int busy_ticks, input bit clr_at_apply,
                        input string tag);
        logic [2:0] c0, c1, mx, nl;
        bool_set: begin end
        cfg_cs1_en = en1;
        for (int i = 0; i < nticks - 1; i++) begin
            tick_pulse();
            chk("R2", "mr_req early", int'(mr_req), 0);
        end
        tick_pulse();
        chk("R2", "mr_req on due tick", int'(mr_req), 1);
        chk("R3", "mr_cs first", int'(mr_cs), 0);
        for (int i = 0; i < busy_ticks; i++) tick_pulse();
        chk("R3", "mr_req held", int'(mr_req), 1);
        mr_ack = 1'b1; mr_data = d0;
        @(negedge clk) mr_ack = 1'b0;
        if (en1) begin
            chk("R3", "cs1 request", int'(mr_req && mr_cs), 1);
            @(negedge clk);
            chk("R3", "cs1 held", int'(mr_req && mr_cs), 1);
            mr_ack = 1'b1; mr_data = d1;
            @(negedge clk) mr_ack = 1'b0;
        end else begin
            chk("R3", "no cs1 request", int'(mr_req), 0);
        end
        // now in the apply cycle
        if (clr_at_apply) begin alert_clr_wr = 1'b1; alert_clr_data = 1'b1; end
        c0 = d0[2:0];
        c1 = en1 ? d1[2:0] : 3'd0;
        mx = (c1 > c0) ? c1 : c0;
        if (mx < 3'd3) mx = 3'd3;
        nl = (mx == 3'd4) ? m_level : mx;
        if (clr_at_apply) m_status = 1'b0;
        if (cfg_irq_en && nl != m_level) m_status = 1'b1;
        m_level = nl;
        exp_q.push_back('{lvl: m_level, st: m_status, tag: tag});
        @(negedge clk);
        alert_clr_wr = 1'b0; alert_clr_data = 1'b0;
        -> done_ev;
        @(negedge clk);
        chk("R10", "idle after poll", int'(mr_req), 0);
    endtask

    task automatic clear_write(input bit d);
        @(negedge clk) begin alert_clr_wr = 1'b1; alert_clr_data = d; end
        @(negedge clk) begin alert_clr_wr = 1'b0; alert_clr_data = 1'b0; end
        if (d) m_status = 1'b0;
        chk("R9", "status after write", int'(alert_status), int'(m_status));
        chk("R9", "irq after write", int'(irq), int'(m_status));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "level", int'(temp_level), 3);
        chk("R1", "sel_ref", int'(sel_ref_derate), 0);
        chk("R1", "sel_tim", int'(sel_tim_derate), 0);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "mr_req", int'(mr_req), 0);
        rst_n = 1'b1;
        cfg_interval = 4'd1;
        @(negedge clk);
        chk("R1", "mr_req after reset", int'(mr_req), 0);

        poll(8'h05, 8'h00, 1'b0, 1, 0, 1'b0, "R4");      // level 5, refresh derate
        clear_write(1'b0);                                // R9 no effect
        clear_write(1'b1);                                // R9 clears
        poll(8'h03, 8'h06, 1'b1, 1, 2, 1'b0, "R4");      // max of both -> 6
        clear_write(1'b1);
        poll(8'h04, 8'h00, 1'b1, 1, 0, 1'b0, "R6");      // reserved, keep 6
        poll(8'hF9, 8'h00, 1'b0, 1, 0, 1'b0, "R5");      // code 1 clamps to 3
        clear_write(1'b1);
        poll(8'h02, 8'h01, 1'b1, 1, 0, 1'b0, "R5");      // still 3, no alert
        cfg_irq_en = 1'b0;
        poll(8'h07, 8'h00, 1'b0, 1, 0, 1'b0, "R8");      // change, alert disabled
        cfg_irq_en = 1'b1;
        poll(8'h04, 8'h05, 1'b1, 1, 0, 1'b0, "R4");      // max 5 from 7
        poll(8'h06, 8'h00, 1'b0, 1, 0, 1'b1, "R9");      // set wins over clear
        poll(8'h06, 8'h00, 1'b0, 1, 0, 1'b1, "R9");      // clear in apply, no set
        cfg_interval = 4'd2;
        poll(8'h06, 8'h00, 1'b0, 2, 5, 1'b0, "R10");     // ticks while busy ignored
        poll(8'h03, 8'h00, 1'b0, 2, 0, 1'b0, "R10");     // count restarted
        cfg_interval = 4'd0;
        poll(8'h05, 8'h00, 1'b0, 1, 0, 1'b0, "R2");      // zero acts as one
        cfg_interval = 4'd15;
        poll(8'h06, 8'h00, 1'b0, 15, 0, 1'b0, "R2");     // largest interval
        repeat (3) @(negedge clk);
        chk("R2", "queue drained", exp_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule